// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is the three-wire write port for a converter's bank of 8-bit control registers. A host lowers an active-low enable, then clocks bits in on the serial data line, most significant bit first. Each bit is taken on a falling edge of the serial clock. Every 16-bit word holds an address byte followed by a data byte. The write lands when the last bit of the word arrives. Several words may be sent in one enable window. A window that ends part-way through a word throws the unfinished bits away.

The serial clock, enable and data lines are brought into the system clock domain through two-stage synchronisers. A falling edge is then detected on the synchronised clock. Because of this, the serial clock may run at any rate and with any duty cycle, provided each high and low phase lasts at least three system clock cycles.

An active-high hardware reset puts every register back to its default value. Writing a 1 to bit 7 of register 0 does the same, and that bit never holds its value.

Bit 0 of register 0 turns on readback mode. The shared status pin normally passes the out-of-range flag through. In readback mode it instead shifts out the addressed register during the data byte of each frame. While readback mode is on, only register 0 accepts writes. The register contents are presented in parallel on one flat output bus for the rest of the chip.

There is no streaming data path, so no valid/ready handshake applies. All pins are plain control or status.

Top module: `cfg_serial_port`

## Requirements
- R1: After hardware reset the register bus reads 0x00 for register 0 and 0x11*k for register k (k = 1..3 at the default depth of 4), and `status_out` follows `ovr_flag`.
- R2: While `sen_n` is low, `sdata` is sampled on each falling `sclk` edge, most significant bit first. Bits 1..8 form the address and bits 9..16 form the data. The register named by the address takes the data at the 16th falling edge. Register k occupies `reg_bits[8k+7:8k]`.
- R3: Several 16-bit words sent back to back in one `sen_n`-low window each write their own register, in order.
- R4: If `sen_n` rises after a number of bits that is not a multiple of 16, the trailing bits cause no write. The next window starts counting at the first address bit.
- R5: Falling `sclk` edges while `sen_n` is high change no register.
- R6: Writing a data byte with bit 7 set to address 0x00 returns every register to its R1 default. Bit 7 of register 0 always reads 0 on `reg_bits`. Other bits of register 0 are stored as written.
- R7: With bit 0 of register 0 clear, `status_out` equals `ovr_flag`. With it set, `status_out` carries readback data and is 0 outside the data byte of a frame.
- R8: In readback mode, `status_out` shows bit 7 of the addressed register after the 8th falling edge of a word, then bit 6 through bit 0 after edges 9 through 15. It returns to 0 after the 16th edge. An address outside the bank reads as all zeros.
- R9: In readback mode, words addressed to any register other than 0x00 are not written. Writes to 0x00 still take effect, so readback can be turned off.
- R10: Writes to addresses at or above the bank depth change no register.
- R11: Writes are correct with a strongly uneven `sclk` duty cycle, in both the short-high/long-low and long-high/short-low cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| hw_rst | input | 1 | Active-high hardware reset, asynchronous, restores defaults |
| sen_n | input | 1 | Serial enable, active low |
| sclk | input | 1 | Serial clock, data taken on falling edge |
| sdata | input | 1 | Serial data in |
| ovr_flag | input | 1 | Out-of-range flag passed to the status pin outside readback |
| status_out | output | 1 | Out-of-range flag or readback bit |
| reg_bits | output | NREG*8 | All register contents, register k at bits 8k+7:8k |

## Verification
If the bit counter is wrong, data lands in the wrong register or with its bits shifted. That shows on `reg_bits` at the very next 16th edge. A counter that fails to clear when the enable rises makes every word of the following window misaligned. A wrong readback shift register or a wrong data-phase flag shows on `status_out` within one serial bit, because every data-phase bit is sampled. A broken write gate in readback mode leaves a changed byte on `reg_bits` right after the suppressed frame.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 8;
  localparam int SRST_BIT  = 7;
  localparam int RDOUT_BIT = 0;

  function automatic logic [DATA_W-1:0] reg_default(input int k);
    return (k == 0) ? '0 : DATA_W'(k * 17);
  endfunction
endpackage

// File: rtl/cfgp_sync.sv
module cfgp_sync #(
  parameter int N = 3,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
        s1 <= RST_VAL[i];
        s2 <= RST_VAL[i];
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/cfgp_shifter.sv
module cfgp_shifter
  import cfgp_pkg::*;
#(
  parameter int WORD_BITS = ADDR_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sen_s,
  input  logic              sclk_s,
  input  logic              sdata_s,
  output logic              bit_stb,
  output logic              addr_stb,
  output logic [ADDR_W-1:0] addr_now,
  output logic              word_stb,
  output logic [ADDR_W-1:0] word_addr,
  output logic [DATA_W-1:0] word_data,
  output logic              data_phase
);
  localparam int CW   = $clog2(WORD_BITS);
  localparam int LAST = WORD_BITS - 1;

  logic                 sclk_d;
  logic [CW-1:0]        cnt;
  logic [WORD_BITS-2:0] sh;
  logic [WORD_BITS-1:0] next_word;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) sclk_d <= 1'b0;
    else     sclk_d <= sclk_s;
  end

  assign bit_stb   = sclk_d & ~sclk_s & ~sen_s;
  assign next_word = {sh, sdata_s};

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cnt <= '0;
      sh  <= '0;
    end else if (sen_s) begin
      cnt <= '0;
      sh  <= '0;
    end else if (bit_stb) begin
      sh  <= next_word[WORD_BITS-2:0];
      cnt <= (cnt == CW'(LAST)) ? '0 : cnt + 1'b1;
    end
  end

  assign addr_stb   = bit_stb && (cnt == CW'(ADDR_W - 1));
  assign addr_now   = next_word[ADDR_W-1:0];
  assign word_stb   = bit_stb && (cnt == CW'(LAST));
  assign word_addr  = next_word[WORD_BITS-1 -: ADDR_W];
  assign word_data  = next_word[DATA_W-1:0];
  assign data_phase = (cnt >= CW'(ADDR_W));

  assert_align_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(sen_s) |=> (cnt == '0));
  assert_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    word_stb |=> (cnt == '0) && !data_phase);
  assert_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({addr_stb, word_stb}));
endmodule

// File: rtl/cfgp_regbank.sv
module cfgp_regbank
  import cfgp_pkg::*;
#(
  parameter int NREG = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_stb,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic                   ld_stb,
  input  logic [ADDR_W-1:0]      ld_addr,
  input  logic                   sh_stb,
  output logic                   readout,
  output logic                   rd_bit,
  output logic [NREG*DATA_W-1:0] q_flat
);
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;

  logic [DATA_W-1:0] q [NREG];
  logic [DATA_W-1:0] rd_shift;
  logic              wr_ok, soft_rst;

  assign readout  = q[0][RDOUT_BIT];
  assign wr_ok    = wr_stb && (wr_addr < ADDR_W'(NREG)) &&
                    (!readout || wr_addr == '0);
  assign soft_rst = wr_ok && (wr_addr == '0) && wr_data[SRST_BIT];

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    localparam logic [DATA_W-1:0] KEEP =
      (k == 0) ? ~(DATA_W'(1) << SRST_BIT) : '1;
    always_ff @(posedge clk or posedge rst) begin
      if (rst)                                   q[k] <= reg_default(k);
      else if (soft_rst)                         q[k] <= reg_default(k);
      else if (wr_ok && wr_addr[IW-1:0] == IW'(k)) q[k] <= wr_data & KEEP;
    end
    assign q_flat[k*DATA_W +: DATA_W] = q[k];
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst)
      rd_shift <= '0;
    else if (ld_stb)
      rd_shift <= (ld_addr < ADDR_W'(NREG)) ? q[ld_addr[IW-1:0]] : '0;
    else if (sh_stb)
      rd_shift <= {rd_shift[DATA_W-2:0], 1'b0};
  end

  assign rd_bit = rd_shift[DATA_W-1];

  assert_softrst_R6: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (q[NREG-1] == reg_default(NREG-1)) && !q[0][SRST_BIT]);
  assert_rd_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (ld_stb && ld_addr >= ADDR_W'(NREG)) |=> (rd_shift == '0));
  assert_unmapped_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && wr_addr >= ADDR_W'(NREG)) |=> $stable(q_flat));
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
  import cfgp_pkg::*;
#(
  parameter int NREG = 4
) (
  input  logic                   clk,
  input  logic                   hw_rst,
  input  logic                   sen_n,
  input  logic                   sclk,
  input  logic                   sdata,
  input  logic                   ovr_flag,
  output logic                   status_out,
  output logic [NREG*DATA_W-1:0] reg_bits
);
  logic              sen_s, sclk_s, sdata_s;
  logic              bit_stb, addr_stb, word_stb, data_phase;
  logic [ADDR_W-1:0] addr_now, word_addr;
  logic [DATA_W-1:0] word_data;
  logic              readout, rd_bit;

  cfgp_sync #(.N(3), .RST_VAL(3'b100)) i_sync (
    .clk(clk), .rst(hw_rst),
    .d({sen_n, sclk, sdata}),
    .q({sen_s, sclk_s, sdata_s})
  );

  cfgp_shifter i_shift (
    .clk(clk), .rst(hw_rst),
    .sen_s(sen_s), .sclk_s(sclk_s), .sdata_s(sdata_s),
    .bit_stb(bit_stb), .addr_stb(addr_stb), .addr_now(addr_now),
    .word_stb(word_stb), .word_addr(word_addr), .word_data(word_data),
    .data_phase(data_phase)
  );

  cfgp_regbank #(.NREG(NREG)) i_bank (
    .clk(clk), .rst(hw_rst),
    .wr_stb(word_stb), .wr_addr(word_addr), .wr_data(word_data),
    .ld_stb(addr_stb), .ld_addr(addr_now), .sh_stb(bit_stb),
    .readout(readout), .rd_bit(rd_bit), .q_flat(reg_bits)
  );

  assign status_out = readout ? (data_phase & rd_bit) : ovr_flag;

  assert_idle_R5: assert property (@(posedge clk) disable iff (hw_rst)
    sen_s |=> $stable(reg_bits));
  assert_rdgate_R9: assert property (@(posedge clk) disable iff (hw_rst)
    (word_stb && readout && word_addr != '0) |=> $stable(reg_bits));
endmodule

// File: tb/test_cfg_serial_port.sv
module test_cfg_serial_port;
  localparam int CLK_P = 10;
  localparam int NREG  = 4;

  logic clk = 0, hw_rst = 1, sen_n = 1, sclk = 1, sdata = 0, ovr_flag = 0;
  logic status_out;
  logic [NREG*8-1:0] reg_bits;
  int n_chk = 0, n_bad = 0;
  int hi_len = 4, lo_len = 6;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  cfg_serial_port #(.NREG(NREG)) i_cfg_serial_port (
    .clk(clk), .hw_rst(hw_rst), .sen_n(sen_n), .sclk(sclk), .sdata(sdata),
    .ovr_flag(ovr_flag), .status_out(status_out), .reg_bits(reg_bits)
  );

  localparam logic [31:0] DEFS = 32'h3322_1100;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sclk = 1; sdata = b;
    wait_clk(hi_len);
    sclk = 0;
    wait_clk(lo_len);
  endtask

  task automatic win_open();
    sen_n = 0; wait_clk(4);
  endtask

  task automatic win_close();
    sclk = 1; wait_clk(4);
    sen_n = 1; wait_clk(6);
  endtask

  task automatic send_word(input logic [7:0] a, input logic [7:0] d);
    for (int i = 7; i >= 0; i--) send_bit(a[i]);
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
  endtask

  task automatic write1(input logic [7:0] a, input logic [7:0] d);
    win_open(); send_word(a, d); win_close();
  endtask

  task automatic t_reset();
    chk("R1 defaults", reg_bits, DEFS);
    ovr_flag = 1; wait_clk(1);
    chk("R1 status follows flag high", status_out, 1);
    ovr_flag = 0; wait_clk(1);
    chk("R1 status follows flag low", status_out, 0);
  endtask

  task automatic t_write();
    write1(8'h01, 8'hA5);
    chk("R2 single write", reg_bits, 32'h3322_A500);
  endtask

  task automatic t_multi();
    win_open();
    send_word(8'h02, 8'h5A);
    send_word(8'h03, 8'hC3);
    send_word(8'h01, 8'h0F);
    win_close();
    chk("R3 three words one window", reg_bits, 32'hC35A_0F00);
  endtask

  task automatic t_partial();
    win_open();
    send_word(8'h02, 8'h77);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    win_close();
    chk("R4 trailing bits dropped", reg_bits, 32'hC377_0F00);
    win_open();
    send_word(8'h01, 8'hEE);
    send_bit(1'b0);
    send_bit(1'b1);
    win_close();
    chk("R4 word then stub", reg_bits, 32'hC377_EE00);
    win_open();
    for (int i = 0; i < 15; i++) send_bit(1'b1);
    win_close();
    chk("R4 fifteen bits no write", reg_bits, 32'hC377_EE00);
    write1(8'h03, 8'h99);
    chk("R4 next window aligned", reg_bits, 32'h9977_EE00);
  endtask

  task automatic t_idle();
    for (int i = 7; i >= 0; i--) send_bit(1'b0);
    for (int i = 7; i >= 0; i--) send_bit(i == 0);
    for (int i = 0; i < 16; i++) send_bit(1'b1);
    sclk = 1; wait_clk(6);
    chk("R5 edges with enable high", reg_bits, 32'h9977_EE00);
  endtask

  task automatic t_unmapped();
    write1(8'h09, 8'h12);
    write1(8'h04, 8'h34);
    chk("R10 unmapped write ignored", reg_bits, 32'h9977_EE00);
  endtask

  task automatic t_softrst();
    write1(8'h00, 8'h02);
    chk("R6 reg0 plain bits stored", reg_bits, 32'h9977_EE02);
    write1(8'h00, 8'h80);
    chk("R6 soft reset to defaults", reg_bits, DEFS);
    chk("R6 bit7 reads zero", reg_bits[7], 0);
  endtask

  task automatic read_chk(input logic [7:0] a, input logic [7:0] exp, input string tag);
    win_open();
    for (int i = 7; i >= 0; i--) send_bit(a[i]);
    chk({tag, " bit7"}, status_out, exp[7]);
    for (int j = 6; j >= 0; j--) begin
      send_bit(1'b0);
      chk($sformatf("%s bit%0d", tag, j), status_out, exp[j]);
    end
    send_bit(1'b0);
    chk({tag, " after word"}, status_out, 0);
    win_close();
  endtask

  task automatic t_readout();
    write1(8'h01, 8'hB4);
    write1(8'h00, 8'h01);
    ovr_flag = 1; wait_clk(1);
    chk("R7 readout idle drives zero", status_out, 0);
    read_chk(8'h01, 8'hB4, "R8 read reg1");
    read_chk(8'h02, 8'h22, "R8 read reg2");
    read_chk(8'h20, 8'h00, "R8 read unmapped");
    write1(8'h03, 8'h44);
    chk("R9 write suppressed", reg_bits, 32'h3322_B401);
    write1(8'h00, 8'h00);
    chk("R9 reg0 still writable", reg_bits, 32'h3322_B400);
    chk("R7 flag restored", status_out, 1);
    ovr_flag = 0; wait_clk(1);
    chk("R7 flag restored low", status_out, 0);
  endtask

  task automatic t_uneven();
    hi_len = 3; lo_len = 30;
    write1(8'h02, 8'h6C);
    chk("R11 short high long low", reg_bits, 32'h336C_B400);
    hi_len = 28; lo_len = 5;
    write1(8'h03, 8'hD1);
    chk("R11 long high short low", reg_bits, 32'hD16C_B400);
    hi_len = 4; lo_len = 6;
  endtask

  task automatic t_hwrst();
    hw_rst = 1; wait_clk(3); hw_rst = 0; wait_clk(4);
    chk("R1 hardware reset restores", reg_bits, DEFS);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    wait_clk(5);
    hw_rst = 0;
    wait_clk(5);
    t_reset();
    t_write();
    t_multi();
    t_partial();
    t_idle();
    t_unmapped();
    t_softrst();
    t_readout();
    t_uneven();
    t_hwrst();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule